// File: doc/BRIEF.md
# Seven-to-one pixel frame serializer

This block turns one parallel video pixel per pixel period into four serial data lanes plus a clock lane, each running at seven bit periods per pixel. On every frame-start strobe it captures a 24-bit RGB pixel together with the horizontal sync, vertical sync and data-enable flags. It arranges these into a 27-bit payload, splits the payload across four 7-slot lanes, and shifts the lanes out one slot per bit clock. A fifth output, the clock lane, carries a fixed 4:3 pattern that is aligned to the lane slots. A receiver uses that pattern to find the frame boundary.

The bit clock (seven times the pixel rate) and a one-cycle frame-start strobe come from outside. A select input chooses which colour bits travel on lane 3: either the two LSBs of each colour or the two MSBs. A mode input reduces the output to 6 bits per colour, keeps lanes 0 to 2 and silences lane 3. The electrical drivers and the generation of the bit clock lie outside this block.

Top module: `pixel_frame_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all lane outputs and `clk_lane` are 0 after that edge, even when `frame_start` is high.
- R2: The clock edge that samples `frame_start` high is slot 0. Over slots 0 to 6, `clk_lane` reads 1,1,0,0,0,1,1.
- R3: The pixel, sync flags, `map_msb_lane3` and `mode_18bit` are captured at the edge that samples `frame_start` high. Slot s appears on the outputs after that edge plus s further edges. Slot 0 of lane 2 is the captured DE.
- R4: The payload bits are f[0..26]. Lane L (L = 0, 1, 2, where `lane_out[L]` is lane L) sends f[7L+6] in slot 0 down to f[7L] in slot 6. With `map_msb_lane3`=0 and `mode_18bit`=0: f[0..5]=R[2..7], f[6]=G[2], f[7..11]=G[3..7], f[12]=B[2], f[13]=B[3], f[14..17]=B[4..7], f[18]=HS, f[19]=VS, f[20]=DE.
- R5: Lane 3 sends f[26] down to f[21] in slots 0 to 5, and 0 in slot 6. In the mapping of R4, f[21..26]=R[0],R[1],G[0],G[1],B[0],B[1].
- R6: With `map_msb_lane3`=1 and `mode_18bit`=0: f[0..5]=R[0..5], f[6]=G[0], f[7..11]=G[1..5], f[12]=B[0], f[13]=B[1], f[14..17]=B[2..5], f[18..20]=HS,VS,DE, f[21..26]=R[6],R[7],G[6],G[7],B[6],B[7].
- R7: With `mode_18bit`=1, lanes 0 to 2 follow the R4 layout. Lane 3 is 0 in every slot. Colour bits [1:0] and `map_msb_lane3` have no effect.
- R8: Pixel and mode inputs that change after the capturing edge have no effect on the frame being sent.
- R9: When no new strobe follows slot 6, all lanes and `clk_lane` are 0 until the next strobe.
- R10: A strobe that arrives before slot 6 abandons the current frame. The next edge shows slot 0 of the newly captured pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven periods per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Capture strobe, starts slot 0 |
| pix_red | input | 8 | Red component |
| pix_green | input | 8 | Green component |
| pix_blue | input | 8 | Blue component |
| pix_hsync | input | 1 | Horizontal sync flag |
| pix_vsync | input | 1 | Vertical sync flag |
| pix_de | input | 1 | Data-enable flag |
| map_msb_lane3 | input | 1 | 0: colour LSBs on lane 3, 1: colour MSBs on lane 3 |
| mode_18bit | input | 1 | 1: 6-bit colour, lane 3 silent |
| lane_out | output | 4 | Serial data lanes, bit L is lane L |
| clk_lane | output | 1 | 4:3 clock-lane pattern |

## Verification
The bench walks a single 1 through every one of the 27 pixel inputs in all four combinations of mapping and colour depth. A swapped or misplaced bit therefore shows up in exactly one lane slot: for example, a lane 3 that sends the reserved zero first, or a mapper that leaves the MSBs on lane 0 in the alternate mapping. It changes the pixel and mode inputs during every frame, which exposes a design that reads its inputs live instead of capturing them. It also checks the idle outputs after a frame without a following strobe, and a strobe that interrupts a frame part-way. A shifter that keeps its old contents or recirculates them would send stale bits or a stuck clock pattern in those cases.

// File: rtl/pfs_pkg.sv
// Package: shared widths and constants for the pixel frame serializer.
// Assumes three colour channels and a lane count that fits the 27-bit
// payload plus one reserved slot.
package pfs_pkg;
    localparam int COLOR_W   = 8;                   // bits per colour input
    localparam int HIGH_W    = 2;                   // colour bits that travel on lane 3
    localparam int LOW_W     = COLOR_W - HIGH_W;    // colour bits on lanes 0..2
    localparam int LANES     = 4;                   // data lanes
    localparam int SLOTS     = 7;                   // bit slots per frame
    localparam int PAYLOAD_W = LANES * SLOTS - 1;   // one reserved slot
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011; // slot 0 at MSB

    typedef enum logic {
        MAP_LSB_ON_LANE3 = 1'b0,
        MAP_MSB_ON_LANE3 = 1'b1
    } lane_map_e;
endpackage

// File: rtl/pfs_frame_mapper.sv
// Module: pfs_frame_mapper
// Combinational. It splits each colour into a field for lanes 0..2 and a
// field for lane 3, according to the mapping select and colour depth. It
// then assembles the 27-bit payload and cuts it into per-lane words. In each
// word the MSB is slot 0. Assumes the inputs are sampled by the caller on
// the frame strobe.
module pfs_frame_mapper
    import pfs_pkg::*;
(
    input  logic [COLOR_W-1:0]          red,
    input  logic [COLOR_W-1:0]          green,
    input  logic [COLOR_W-1:0]          blue,
    input  logic                        hsync,
    input  logic                        vsync,
    input  logic                        de,
    input  lane_map_e                   map_sel,
    input  logic                        mode_18,
    output logic [LANES-1:0][SLOTS-1:0] lane_words
);
    logic [2:0][COLOR_W-1:0] colours;
    logic [2:0][LOW_W-1:0]   low_field;
    logic [2:0][HIGH_W-1:0]  high_field;
    logic [PAYLOAD_W-1:0]    payload;

    assign colours = {blue, green, red};

    // Per colour: choose which bits go to lanes 0..2 and which to lane 3.
    for (genvar c = 0; c < 3; c++) begin : g_split
        always_comb begin
            if (mode_18) begin
                low_field[c]  = colours[c][COLOR_W-1:HIGH_W];
                high_field[c] = '0;
            end else if (map_sel == MAP_MSB_ON_LANE3) begin
                low_field[c]  = colours[c][LOW_W-1:0];
                high_field[c] = colours[c][COLOR_W-1:LOW_W];
            end else begin
                low_field[c]  = colours[c][COLOR_W-1:HIGH_W];
                high_field[c] = colours[c][HIGH_W-1:0];
            end
        end
    end

    // Payload assembly: the bit positions are fixed by the lane format.
    always_comb begin
        payload        = '0;
        payload[5:0]   = low_field[0];
        payload[6]     = low_field[1][0];
        payload[11:7]  = low_field[1][5:1];
        payload[13:12] = low_field[2][1:0];
        payload[17:14] = low_field[2][5:2];
        payload[18]    = hsync;
        payload[19]    = vsync;
        payload[20]    = de;
        payload[22:21] = high_field[0];
        payload[24:23] = high_field[1];
        payload[26:25] = high_field[2];
    end

    // Lane words: the lowest lanes take 7 payload bits each; the last lane
    // sends its payload bits first and the reserved zero in the final slot.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l < LANES - 1) begin : g_full
            assign lane_words[l] = payload[l*SLOTS +: SLOTS];
        end else begin : g_last
            assign lane_words[l] = {payload[l*SLOTS +: SLOTS-1], 1'b0};
        end
    end
endmodule

// File: rtl/pfs_lane_shifter.sv
// Module: pfs_lane_shifter
// Parallel-load, MSB-first shift register for one serial lane. A load
// replaces the contents at once. Otherwise zeros shift in, so the lane goes
// quiet once the word is sent. Synchronous active-low reset.
module pfs_lane_shifter #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] word,
    output logic             serial
);
    logic [WIDTH-1:0] shreg;

    // Load on strobe, otherwise shift towards the MSB with zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= word;
        end else begin
            shreg <= {shreg[WIDTH-2:0], 1'b0};
        end
    end

    assign serial = shreg[WIDTH-1];
endmodule

// File: rtl/pixel_frame_serializer.sv
// Module: pixel_frame_serializer (top)
// Captures one pixel per frame strobe and serializes it onto four data
// lanes plus a 4:3 clock lane. The slot after the strobe edge is slot 0.
// Assumes the strobe recurs every SLOTS bit clocks in normal operation and
// that the bit clock is supplied from outside.
module pixel_frame_serializer
    import pfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [COLOR_W-1:0] pix_red,
    input  logic [COLOR_W-1:0] pix_green,
    input  logic [COLOR_W-1:0] pix_blue,
    input  logic               pix_hsync,
    input  logic               pix_vsync,
    input  logic               pix_de,
    input  logic               map_msb_lane3,
    input  logic               mode_18bit,
    output logic [LANES-1:0]   lane_out,
    output logic               clk_lane
);
    logic [LANES-1:0][SLOTS-1:0] lane_words;

    pfs_frame_mapper u_mapper (
        .red        (pix_red),
        .green      (pix_green),
        .blue       (pix_blue),
        .hsync      (pix_hsync),
        .vsync      (pix_vsync),
        .de         (pix_de),
        .map_sel    (lane_map_e'(map_msb_lane3)),
        .mode_18    (mode_18bit),
        .lane_words (lane_words)
    );

    // One shifter per data lane, all loaded by the same strobe.
    for (genvar l = 0; l < LANES; l++) begin : g_data
        pfs_lane_shifter #(.WIDTH(SLOTS)) u_shift (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (frame_start),
            .word   (lane_words[l]),
            .serial (lane_out[l])
        );
    end

    // Clock lane: the same shifter loaded with the fixed pattern keeps it
    // in step with the data slots.
    pfs_lane_shifter #(.WIDTH(SLOTS)) u_clk_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_start),
        .word   (CLK_PATTERN),
        .serial (clk_lane)
    );
endmodule

// File: rtl/pfs_checker.sv
// Module: pfs_checker
// Tracks the slot number independently of the design and checks the clock
// lane, the reserved slot, lane 3 silence in 18-bit mode and idle
// behaviour. Bound to the top module.
module pfs_checker
    import pfs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             pix_de,
    input logic             mode_18bit,
    input logic [LANES-1:0] lane_out,
    input logic             clk_lane
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(SLOTS);

    logic [CNT_W-1:0] slot;
    logic             cap_m18;
    logic             cap_de;

    // Slot counter: 0 after a strobe, saturates at IDLE after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot    <= IDLE;
            cap_m18 <= 1'b0;
            cap_de  <= 1'b0;
        end else if (frame_start) begin
            slot    <= '0;
            cap_m18 <= mode_18bit;
            cap_de  <= pix_de;
        end else if (slot != IDLE) begin
            slot    <= slot + 1'b1;
        end
    end

    AST_CLK_LANE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != IDLE) |-> (clk_lane == ((slot < 2) || (slot > 4)))); // R2
    AST_FIRST_SLOT_DE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 0) |-> (lane_out[2] == cap_de)); // R3
    AST_RESERVED_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == CNT_W'(SLOTS - 1)) |-> !lane_out[LANES-1]); // R5
    AST_LANE3_SILENT_18: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot != IDLE) && cap_m18) |-> !lane_out[LANES-1]); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == IDLE) |-> ((lane_out == '0) && !clk_lane)); // R9
endmodule

bind pixel_frame_serializer pfs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_de      (pix_de),
    .mode_18bit  (mode_18bit),
    .lane_out    (lane_out),
    .clk_lane    (clk_lane)
);

// File: tb/pixel_frame_serializer_tb.sv
// Bench: sweeps walking-one and pseudo-random pixels through all mapping
// and depth combinations. Expected lane bits are computed from the
// requirement tables.
module pixel_frame_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] pix_red = '0, pix_green = '0, pix_blue = '0;
    logic       pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0;
    logic       map_msb_lane3 = 1'b0, mode_18bit = 1'b0;
    logic [3:0] lane_out;
    logic       clk_lane;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    pixel_frame_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
        .map_msb_lane3(map_msb_lane3), .mode_18bit(mode_18bit),
        .lane_out(lane_out), .clk_lane(clk_lane)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Payload from the requirement tables; v = {de, vs, hs, b, g, r}.
    function automatic logic [26:0] ref_payload(input logic [26:0] v, input bit msb, input bit m18);
        logic [7:0] r, g, b;
        logic [26:0] f;
        bit alt;
        r = v[7:0]; g = v[15:8]; b = v[23:16];
        alt = msb && !m18;
        f = '0;
        for (int i = 0; i < 6; i++) f[i] = alt ? r[i] : r[i+2];
        f[6] = alt ? g[0] : g[2];
        for (int i = 0; i < 5; i++) f[7+i] = alt ? g[1+i] : g[3+i];
        f[12] = alt ? b[0] : b[2];
        f[13] = alt ? b[1] : b[3];
        for (int i = 0; i < 4; i++) f[14+i] = alt ? b[2+i] : b[4+i];
        f[18] = v[24]; f[19] = v[25]; f[20] = v[26];
        if (!m18) begin
            f[21] = alt ? r[6] : r[0];
            f[22] = alt ? r[7] : r[1];
            f[23] = alt ? g[6] : g[0];
            f[24] = alt ? g[7] : g[1];
            f[25] = alt ? b[6] : b[0];
            f[26] = alt ? b[7] : b[1];
        end
        return f;
    endfunction

    function automatic logic [3:0] ref_slot(input logic [26:0] f, input int s);
        logic [3:0] o;
        for (int l = 0; l < 3; l++) o[l] = f[7*l + 6 - s];
        o[3] = (s < 6) ? f[26 - s] : 1'b0;
        return o;
    endfunction

    function automatic logic [26:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[31:5];
    endfunction

    task automatic apply_pixel(input logic [26:0] v, input bit msb, input bit m18);
        pix_red = v[7:0]; pix_green = v[15:8]; pix_blue = v[23:16];
        pix_hsync = v[24]; pix_vsync = v[25]; pix_de = v[26];
        map_msb_lane3 = msb; mode_18bit = m18;
    endtask

    // Starts at a negedge: drives the strobe, then checks nslots slots.
    // Inputs are scrambled after the capture edge (R8).
    task automatic send_frame(input logic [26:0] v, input bit msb, input bit m18,
                              input int nslots, input string tag);
        logic [26:0] f;
        string t3;
        f = ref_payload(v, msb, m18);
        apply_pixel(v, msb, m18);
        frame_start = 1'b1;
        t3 = (tag != "") ? tag : (m18 ? "R7" : (msb ? "R6" : "R5"));
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk);
            if (s == 0) begin
                frame_start = 1'b0;
                apply_pixel(~v, ~msb, ~m18);
            end
            chk((tag != "") ? tag : (m18 ? "R7" : (msb ? "R6" : "R4")),
                {1'b0, lane_out[2:0]}, {1'b0, ref_slot(f, s)[2:0]});
            chk(t3, {3'b0, lane_out[3]}, {3'b0, ref_slot(f, s)[3]});
            chk("R2", {3'b0, clk_lane}, {3'b0, (s < 2) || (s > 4)});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R1: strobe and pixel active while reset is held.
        apply_pixel('1, 1'b0, 1'b0);
        frame_start = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", lane_out, 4'b0);
        chk("R1", {3'b0, clk_lane}, 4'b0);
        frame_start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {lane_out[3:1], clk_lane}, 4'b0);

        // R3: slot 0 after the strobe edge carries DE on lane 2.
        send_frame(27'h400_0000, 1'b0, 1'b0, 7, "R3");
        send_frame(27'h000_00FF, 1'b0, 1'b0, 7, "R8");

        // Walking one and pseudo-random sweep across all mode combinations.
        for (int mode = 0; mode < 4; mode++) begin
            for (int i = 0; i < 27; i++)
                send_frame(27'(1) << i, mode[0], mode[1], 7, "");
            send_frame('1, mode[0], mode[1], 7, "");
            for (int k = 0; k < 8; k++)
                send_frame(next_rand(), mode[0], mode[1], 7, "");
        end

        // R9: no further strobe, everything goes quiet.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9", lane_out, 4'b0);
            chk("R9", {3'b0, clk_lane}, 4'b0);
        end

        // R10: an early strobe restarts the frame with the new pixel.
        send_frame(27'h7FF_FFFF, 1'b1, 1'b0, 3, "R10");
        send_frame(27'h155_AA33, 1'b0, 1'b0, 7, "R10");
        send_frame(next_rand(), 1'b1, 1'b0, 5, "R10");
        send_frame(next_rand(), 1'b0, 1'b1, 7, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule